// File: doc/BRIEF.md
# Multi-Port Bus Address Router

This block sits between three requesters and four 32-bit downstream ports. The requesters are instruction fetch, core data and debug. Each request carries an address, a write flag, a size and write data. The router decodes the address against a fixed region map and also looks at which requester issued it. It then steers the request to one of four ports:

- a code-instruction port
- a code-data port
- a system port
- a peripheral port

The ready and read data from that port are returned to the requester.

Several requesters may aim at the same port in the same cycle. In that case the router grants one of them by a fixed priority: data first, then fetch, then debug. The losers see ready low and must hold their request stable. A granted requester keeps its port until its transfer completes. Two kinds of request never reach a port and are answered at once with an error:

- any access to a small internal window
- an instruction fetch aimed at the peripheral window

Top module: `bus_router`

## Requirements
- R1: A fetch with address below 0x20000000 is issued on the code-instruction port (port index 0). That port always presents size 2 (word; size encoding 0 = byte, 1 = half, 2 = word) and write low.
- R2: A debug request never appears on the code-instruction port. Debug to addresses below 0x20000000 uses the code-data port.
- R3: Data and debug requests with address below 0x20000000 go to the code-data port (index 1). When both want it in the same cycle, data wins and debug waits.
- R4: Requests from any source to 0x20000000–0xDFFFFFFF or 0xE0100000–0xFFFFFFFF go to the system port (index 2), carrying the requester's address, write flag, size and write data.
- R5: On the system port the order of precedence, highest first, is data, fetch, debug.
- R6: Data and debug requests to 0xE0040000–0xE00FFFFF go to the peripheral port (index 3), with data ahead of debug. Only address bits [19:0] are driven; bits [31:20] of that port's address are zero.
- R7: A request from any source to 0xE0000000–0xE003FFFF reaches no port. It gets ready and error high in the same cycle.
- R8: A fetch to 0xE0040000–0xE00FFFFF reaches no port. It gets ready and error high in the same cycle.
- R9: A granted source keeps its port, whatever higher-priority requests arrive, until a cycle in which the port's ready is high. A source that is not granted sees ready low. A granted source sees ready equal to its port's ready, together with that port's read data.
- R10: After reset, with no requests, no port is valid and no source sees ready or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 3 | Request per source (0 data, 1 fetch, 2 debug) |
| src_addr | input | 3x32 | Address per source |
| src_write | input | 3 | Write flag per source |
| src_size | input | 3x2 | Access size per source |
| src_wdata | input | 3x32 | Write data per source |
| src_ready | output | 3 | Transfer completes this cycle |
| src_err | output | 3 | Error response, valid with ready |
| src_rdata | output | 3x32 | Read data returned to the source |
| prt_valid | output | 4 | Request presented on each port |
| prt_addr | output | 4x32 | Address per port |
| prt_write | output | 4 | Write flag per port |
| prt_size | output | 4x2 | Size per port |
| prt_wdata | output | 4x32 | Write data per port |
| prt_ready | input | 4 | Port completes the presented transfer |
| prt_rdata | input | 4x32 | Read data per port |

## Verification
The bench builds the router with its default widths: 32-bit data and address, three sources, four ports and a 20-bit peripheral address. These values put every region edge within reach of the stimulus, such as 0x1FFFFFFC, 0xE003FFFF and 0xE0100000, alongside random offsets. Port ready is stalled at random, so grants stay locked across several cycles while higher-priority requests arrive. Contention on each shared port then exercises both the fixed priority order and the hold of an owner already granted.

// File: rtl/busrt_pkg.sv
// Shared constants and types for the bus router.
// Assumes a 32-bit address space and the fixed region map below.
package busrt_pkg;
    localparam int NSRC  = 3;
    localparam int NPORT = 4;
    localparam int AW    = 32;
    localparam int DW    = 32;

    // Source indices; a lower index has higher priority on every port.
    localparam int SRC_DATA  = 0;
    localparam int SRC_FETCH = 1;
    localparam int SRC_DEBUG = 2;

    // Port indices.
    localparam int PORT_CI  = 0;
    localparam int PORT_CD  = 1;
    localparam int PORT_SYS = 2;
    localparam int PORT_PER = 3;

    // Region boundaries.
    localparam logic [AW-1:0] CODE_END  = 32'h2000_0000;
    localparam logic [AW-1:0] INT_BASE  = 32'hE000_0000;
    localparam logic [AW-1:0] PER_BASE  = 32'hE004_0000;
    localparam logic [AW-1:0] PER_END   = 32'hE010_0000;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef struct packed {
        logic       hit;   // request goes to a port
        logic       err;   // request answered locally with error
        logic [1:0] port;  // target port when hit
    } route_t;
endpackage

// File: rtl/busrt_decode.sv
// Region decoder for one source.
// Maps an address to a target port, or to a local error, using the fixed map.
// IS_FETCH selects the rules for instruction fetches.
// Assumes the address is stable while the request is held.
module busrt_decode
    import busrt_pkg::*;
#(
    parameter bit IS_FETCH = 1'b0
) (
    input  logic [AW-1:0] addr,
    output route_t        route
);
    logic in_code, in_int, in_per;

    // Classify the address into regions.
    always_comb begin
        in_code = addr < CODE_END;
        in_int  = (addr >= INT_BASE) && (addr < PER_BASE);
        in_per  = (addr >= PER_BASE) && (addr < PER_END);
    end

    // Choose the target port or a local error.
    always_comb begin
        route = '{hit: 1'b1, err: 1'b0, port: 2'(PORT_SYS)};
        if (in_int) begin
            route = '{hit: 1'b0, err: 1'b1, port: 2'd0};
        end else if (in_per) begin
            if (IS_FETCH) route = '{hit: 1'b0, err: 1'b1, port: 2'd0};
            else          route = '{hit: 1'b1, err: 1'b0, port: 2'(PORT_PER)};
        end else if (in_code) begin
            route.port = IS_FETCH ? 2'(PORT_CI) : 2'(PORT_CD);
        end
    end

    // A fetch must never be steered to the peripheral port.
    always_comb begin
        assert_fetch_not_per_R8: assert (!(IS_FETCH && route.hit && route.port == 2'(PORT_PER)));
    end
endmodule

// File: rtl/busrt_arb.sv
// Fixed-priority arbiter with hold, one per port.
// The lowest set bit of want wins. The winner keeps the port until done.
// Assumes a held requester keeps its request asserted until done.
module busrt_arb #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] want,
    input  logic         done,
    output logic [N-1:0] grant
);
    logic         locked_q;
    logic [N-1:0] owner_q;
    logic [N-1:0] pick;

    // Lowest-index requester wins when the port is free.
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (want[i]) pick = N'(1) << i;
        end
    end

    // Current grant: the held owner, or a fresh pick.
    always_comb grant = locked_q ? owner_q : pick;

    // Lock the port while a granted transfer is stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            owner_q  <= '0;
        end else begin
            locked_q <= (|grant) && !done;
            owner_q  <= grant;
        end
    end

    assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_hold_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant) && !done) |=> (grant == $past(grant)));
endmodule

// File: rtl/bus_router.sv
// Bus router top.
// Decodes each source, arbitrates each port, and muxes requests out and responses back.
// Assumes each source holds its request stable until it sees ready.
module bus_router
    import busrt_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSRC-1:0]            src_req,
    input  logic [NSRC-1:0][AW-1:0]    src_addr,
    input  logic [NSRC-1:0]            src_write,
    input  logic [NSRC-1:0][1:0]       src_size,
    input  logic [NSRC-1:0][DW-1:0]    src_wdata,
    output logic [NSRC-1:0]            src_ready,
    output logic [NSRC-1:0]            src_err,
    output logic [NSRC-1:0][DW-1:0]    src_rdata,
    output logic [NPORT-1:0]           prt_valid,
    output logic [NPORT-1:0][AW-1:0]   prt_addr,
    output logic [NPORT-1:0]           prt_write,
    output logic [NPORT-1:0][1:0]      prt_size,
    output logic [NPORT-1:0][DW-1:0]   prt_wdata,
    input  logic [NPORT-1:0]           prt_ready,
    input  logic [NPORT-1:0][DW-1:0]   prt_rdata
);
    localparam int PER_AW = 20;

    route_t [NSRC-1:0]            route;
    logic   [NPORT-1:0][NSRC-1:0] want;
    logic   [NPORT-1:0][NSRC-1:0] grant;

    // One decoder per source; only the fetch source uses the fetch rules.
    for (genvar s = 0; s < NSRC; s++) begin : g_dec
        busrt_decode #(.IS_FETCH(s == SRC_FETCH)) u_dec (
            .addr  (src_addr[s]),
            .route (route[s])
        );
    end

    // Per-port request vectors.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            for (int s = 0; s < NSRC; s++) begin
                want[p][s] = src_req[s] && route[s].hit && (route[s].port == 2'(p));
            end
        end
    end

    // One arbiter per port.
    for (genvar p = 0; p < NPORT; p++) begin : g_arb
        busrt_arb #(.N(NSRC)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (want[p]),
            .done  (prt_ready[p]),
            .grant (grant[p])
        );
    end

    // Drive each port from its granted source.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            prt_valid[p] = |grant[p];
            prt_addr[p]  = '0;
            prt_write[p] = 1'b0;
            prt_size[p]  = '0;
            prt_wdata[p] = '0;
            for (int s = 0; s < NSRC; s++) begin
                if (grant[p][s]) begin
                    prt_addr[p]  = src_addr[s];
                    prt_write[p] = src_write[s];
                    prt_size[p]  = src_size[s];
                    prt_wdata[p] = src_wdata[s];
                end
            end
        end
        prt_size[PORT_CI]  = SIZE_WORD;
        prt_write[PORT_CI] = 1'b0;
        prt_addr[PORT_PER] = {{(AW-PER_AW){1'b0}}, prt_addr[PORT_PER][PER_AW-1:0]};
    end

    // Return ready, error and read data to each source.
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            src_err[s]   = src_req[s] && route[s].err;
            src_ready[s] = src_err[s];
            src_rdata[s] = '0;
            for (int p = 0; p < NPORT; p++) begin
                if (grant[p][s]) begin
                    src_ready[s] = prt_ready[p];
                    src_rdata[s] = prt_rdata[p];
                end
            end
        end
    end

    assert_no_debug_ci_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prt_valid[PORT_CI] |-> !grant[PORT_CI][SRC_DEBUG]);

    for (genvar s = 0; s < NSRC; s++) begin : g_chk
        assert_err_no_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
            src_err[s] |-> (grant[PORT_CI][s] == 1'b0 && grant[PORT_CD][s] == 1'b0 &&
                            grant[PORT_SYS][s] == 1'b0 && grant[PORT_PER][s] == 1'b0));

        assert_loser_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (src_req[s] && !src_err[s] && !grant[route[s].port][s]) |-> !src_ready[s]);
    end
endmodule

// File: tb/bus_router_bench.sv
`timescale 1ns/1ps
module bus_router_bench;
    localparam int NS = 3;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]        src_req = '0;
    logic [NS-1:0][31:0]  src_addr = '0;
    logic [NS-1:0]        src_write = '0;
    logic [NS-1:0][1:0]   src_size = '0;
    logic [NS-1:0][31:0]  src_wdata = '0;
    logic [NS-1:0]        src_ready;
    logic [NS-1:0]        src_err;
    logic [NS-1:0][31:0]  src_rdata;
    logic [NP-1:0]        prt_valid;
    logic [NP-1:0][31:0]  prt_addr;
    logic [NP-1:0]        prt_write;
    logic [NP-1:0][1:0]   prt_size;
    logic [NP-1:0][31:0]  prt_wdata;
    logic [NP-1:0]        prt_ready = '0;
    logic [NP-1:0][31:0]  prt_rdata;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bus_router u_bus_router (
        .clk(clk), .rst_n(rst_n),
        .src_req(src_req), .src_addr(src_addr), .src_write(src_write),
        .src_size(src_size), .src_wdata(src_wdata),
        .src_ready(src_ready), .src_err(src_err), .src_rdata(src_rdata),
        .prt_valid(prt_valid), .prt_addr(prt_addr), .prt_write(prt_write),
        .prt_size(prt_size), .prt_wdata(prt_wdata),
        .prt_ready(prt_ready), .prt_rdata(prt_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference target: 0..3 port, 4 local error.
    function automatic int target(input int s, input logic [31:0] a);
        if (a >= 32'hE000_0000 && a <= 32'hE003_FFFF) return 4;
        if (a >= 32'hE004_0000 && a <= 32'hE00F_FFFF) return (s == 1) ? 4 : 3;
        if (a <= 32'h1FFF_FFFF) return (s == 1) ? 0 : 1;
        return 2;
    endfunction

    function automatic logic [31:0] pick_addr();
        int r = $urandom % 14;
        case (r)
            0, 1, 2: return ($urandom % 32'h2000_0000) & 32'hFFFF_FFFC;
            3, 4:    return 32'h2000_0000 + ($urandom % 32'hC000_0000);
            5:       return 32'hE004_0000 + ($urandom % 32'h000C_0000);
            6:       return 32'hE000_0000 + ($urandom % 32'h0004_0000);
            7:       return 32'hE010_0000 + ($urandom % 32'h1FF0_0000);
            8:       return 32'h1FFF_FFFC;
            9:       return 32'h2000_0000;
            10:      return 32'hE003_FFFF;
            11:      return 32'hE004_0000;
            12:      return 32'hE00F_FFFF;
            default: return 32'hE010_0000;
        endcase
    endfunction

    int  m_lock [NP];
    int  m_own  [NP];
    bit  done   [NS];

    // Compare every output against the behavioural model, then advance the model.
    task automatic model_step();
        int tg [NS];
        int own [NP];
        bit dbg_code = 0;
        for (int s = 0; s < NS; s++) begin
            tg[s] = src_req[s] ? target(s, src_addr[s]) : -1;
            if (s == 2 && tg[s] == 1) dbg_code = 1;
        end
        for (int p = 0; p < NP; p++) begin
            own[p] = -1;
            if (m_lock[p] != 0) own[p] = m_own[p];
            else for (int s = NS - 1; s >= 0; s--) if (tg[s] == p) own[p] = s;
        end
        for (int p = 0; p < NP; p++) begin
            string tv;
            tv = (p == 0) ? (dbg_code ? "R2" : "R1") : (p == 1) ? "R3" : (p == 2) ? "R5" : "R6";
            if (!rst_n) tv = "R10";
            chk(tv, 32'(prt_valid[p]), 32'(own[p] >= 0));
            if (own[p] >= 0) begin
                logic [31:0] ea = src_addr[own[p]];
                if (p == 3) ea = ea & 32'h000F_FFFF;
                chk((p == 3) ? "R6" : (p == 2) ? "R4" : (p == 1) ? "R3" : "R1", prt_addr[p], ea);
                if (p == 0) begin
                    chk("R1", 32'(prt_size[0]), 32'd2);
                    chk("R1", 32'(prt_write[0]), 32'd0);
                end else begin
                    chk("R4", 32'(prt_size[p]), 32'(src_size[own[p]]));
                    chk("R4", 32'(prt_write[p]), 32'(src_write[own[p]]));
                    chk("R4", prt_wdata[p], src_wdata[own[p]]);
                end
            end
        end
        for (int s = 0; s < NS; s++) begin
            bit er = (tg[s] == 4);
            bit rd = er || (tg[s] >= 0 && own[tg[s]] == s && prt_ready[tg[s]]);
            string te = (s == 1 && src_addr[s] >= 32'hE004_0000) ? "R8" : "R7";
            chk(rst_n ? te : "R10", 32'(src_err[s]), 32'(er));
            chk(rst_n ? "R9" : "R10", 32'(src_ready[s]), 32'(rd));
            if (rd && !er) chk("R9", src_rdata[s], prt_rdata[tg[s]]);
            done[s] = rd;
        end
        for (int p = 0; p < NP; p++) begin
            if (!rst_n) m_lock[p] = 0;
            else begin
                m_lock[p] = (own[p] >= 0 && !prt_ready[p]) ? 1 : 0;
                m_own[p]  = own[p];
            end
        end
    endtask

    for (genvar p = 0; p < NP; p++) begin : g_rd
        assign prt_rdata[p] = 32'hA5A5_0000 ^ (32'(p) << 24) ^ prt_addr[p];
    end

    initial begin
        for (int p = 0; p < NP; p++) begin m_lock[p] = 0; m_own[p] = -1; end
        for (int s = 0; s < NS; s++) done[s] = 1;
        repeat (3) begin
            @(negedge clk);
            #1.5 model_step();
        end
        rst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            #1.5 model_step();
        end
        // Directed: all three sources to the system port at once, port stalled.
        @(negedge clk);
        src_req = 3'b111;
        src_addr[0] = 32'h3000_0000; src_addr[1] = 32'h3000_0004; src_addr[2] = 32'h3000_0008;
        prt_ready = '0;
        #1.5 model_step();
        @(negedge clk);
        #1.5 chk("R5", prt_addr[2], 32'h3000_0000);
        model_step();
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            for (int s = 0; s < NS; s++) begin
                if (done[s] || !src_req[s]) begin
                    src_req[s]   = ($urandom % 5) != 0;
                    src_addr[s]  = pick_addr();
                    src_write[s] = $urandom % 2;
                    src_size[s]  = 2'($urandom % 3);
                    src_wdata[s] = $urandom;
                end
            end
            prt_ready = 4'($urandom);
            #1.5 model_step();
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule